// File: doc/BRIEF.md
# SPI Command Frame Monitor

This block listens, without driving anything, to a four-wire SPI bus (select, clock, controller-out and controller-in data) that carries the command set of a small Ethernet controller. The bus is sampled in the system clock domain. Each period during which select is held low is treated as one command frame. The block assembles mode-0 bytes from both data lines. When select returns high, it decodes the header byte, checks the frame length against the command, and reports the result with a single-cycle pulse.

The monitor keeps its own copy of the controller's two-bit register bank. It updates that copy from the writes, bit-set, bit-clear and reset commands it observes. Each bank bit has its own validity flag. With this state the monitor can label register reads by class. It flags a read of a MAC/MII-class register that omits the dummy byte, and a read of an ordinary register that includes one.

Top module: `spi_cmd_monitor`

## Requirements
- R1: A report (`rpt_valid` high for exactly one cycle) is produced only after select rises following a select fall, and only when at least one whole byte was seen. An empty frame, or a frame with fewer than 8 clock edges, yields no report. Trailing bits that do not complete a byte are discarded.
- R2: `rpt_op` is bits 7:5 and `rpt_addr` is bits 4:0 of the first MOSI byte. Opcode 3'b110 sets flag bit 0 (unknown opcode) and no other flag.
- R3: A buffer read (opcode 001) needs header 0x3A and a buffer write (opcode 011) needs header 0x7A; otherwise flag bit 1 is set. A valid buffer command reports `rpt_len` as the byte count minus one, saturating at 2^LEN_W-1. For all other cases `rpt_len` is 0.
- R4: Control write, bit set and bit clear must be exactly 2 bytes, system reset exactly 1 byte, and control read 2 or 3 bytes. Any other length sets flag bit 2 only and leaves the bank state unchanged.
- R5: For address 0x1F, a control write loads bank bits 1:0 from MOSI byte 1 and marks both known. A bit set forces to 1, and a bit clear forces to 0, each bank bit whose mask bit in MOSI byte 1 is 1, marking that bit known. Commands to other addresses leave the bank alone.
- R6: A 1-byte system reset (opcode 111) sets the bank to 0 with both bits known.
- R7: After reset both bank bits are unknown. `rpt_bank_known` is high only when both are known, and `rpt_bank` then shows the bank in effect before the frame (0 otherwise). A correctly sized register command (control read, control write, bit set, bit clear) issued while either bit is unknown sets flag bit 3.
- R8: A control read reports MISO byte 1 as data in a 2-byte frame, and MISO byte 2 in a 3-byte frame.
- R9: With the bank known, a control read of a MAC/MII-class register (bank 2 addresses 0x00–0x19, bank 3 addresses 0x00–0x05) in a 2-byte frame, or of any other register in a 3-byte frame, sets flag bit 4.
- R10: With the bank known, a register command to a reserved address (0x1A in any bank, or 0x0F–0x11 in bank 3) sets flag bit 5.
- R11: Control write, bit set and bit clear report MOSI byte 1 as data. Buffer commands, reset and rejected frames report data 0.
- R12: Bits are captured on the rising SCK edge while select is low, most significant bit first, on both data lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Bus select, active low (asynchronous) |
| spi_sck | input | 1 | Bus clock (asynchronous) |
| spi_mosi | input | 1 | Controller-out data |
| spi_miso | input | 1 | Controller-in data |
| rpt_valid | output | 1 | One-cycle report strobe |
| rpt_op | output | 3 | Decoded opcode |
| rpt_addr | output | 5 | Register address field |
| rpt_bank | output | 2 | Bank before this frame, 0 if unknown |
| rpt_bank_known | output | 1 | Both bank bits known |
| rpt_data | output | 8 | Data byte of the command |
| rpt_len | output | LEN_W | Buffer payload length |
| rpt_flags | output | 6 | Error flags: 0 opcode, 1 header, 2 length, 3 bank unknown, 4 dummy byte, 5 reserved |

## Verification
The bench targets partial banks, where only one bank bit has been set through a bit-set command. A design that keeps a single validity bit would report a bank too early. It checks that a wrongly sized bank-select write leaves the bank untouched; a design that updated before checking the length would move the bank. It mixes 2- and 3-byte reads across register classes, which exposes a wrong MISO byte selection or an inverted dummy rule. It also checks saturation of long buffer payloads and dropped partial bits. A design that counted a partial byte, or let the length wrap, would report wrong lengths or spurious frames.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;

  typedef enum logic [2:0] {
    OP_RD_CTL  = 3'b000,
    OP_RD_BUF  = 3'b001,
    OP_WR_CTL  = 3'b010,
    OP_WR_BUF  = 3'b011,
    OP_BIT_SET = 3'b100,
    OP_BIT_CLR = 3'b101,
    OP_UNUSED  = 3'b110,
    OP_SYS_RST = 3'b111
  } op_e;

  localparam int FLAG_W  = 6;
  localparam int F_OPC   = 0;
  localparam int F_HDR   = 1;
  localparam int F_LEN   = 2;
  localparam int F_BANK  = 3;
  localparam int F_DUMMY = 4;
  localparam int F_RSVD  = 5;

  localparam logic [4:0] BANK_SEL_ADDR = 5'h1F;
  localparam logic [7:0] RD_BUF_HDR    = 8'h3A;
  localparam logic [7:0] WR_BUF_HDR    = 8'h7A;

  // Register class map, computed per bank
  function automatic logic is_mac_reg(input logic [1:0] bank, input logic [4:0] a);
    return ((bank == 2'd2) && (a <= 5'h19)) || ((bank == 2'd3) && (a <= 5'h05));
  endfunction

  function automatic logic is_rsvd_reg(input logic [1:0] bank, input logic [4:0] a);
    return (a == 5'h1A) || ((bank == 2'd3) && (a >= 5'h0F) && (a <= 5'h11));
  endfunction

endpackage

// File: rtl/spi_mon_sync.sv
module spi_mon_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[g] <= RST_VAL;
      else if (g == 0) stage[g] <= d;
      else stage[g] <= stage[(g == 0) ? 0 : g-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_mon_deser.sv
module spi_mon_deser #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csn,
  input  logic             sck,
  input  logic             mosi,
  input  logic             miso,
  output logic             frame_done,
  output logic [CNT_W-1:0] byte_cnt,
  output logic [7:0]       hdr,
  output logic [7:0]       mosi1,
  output logic [7:0]       miso1,
  output logic [7:0]       miso2
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(1) << (CNT_W-1);

  logic       csn_d, sck_d, active;
  logic [2:0] bit_idx;
  logic [7:0] sh_mosi, sh_miso;
  logic [7:0] nxt_mosi, nxt_miso;
  logic       cs_fall, cs_rise, sck_rise;

  assign cs_fall  = csn_d & ~csn;
  assign cs_rise  = ~csn_d & csn;
  assign sck_rise = ~sck_d & sck;
  assign nxt_mosi = {sh_mosi[6:0], mosi};
  assign nxt_miso = {sh_miso[6:0], miso};

  always_ff @(posedge clk) begin
    if (rst) begin
      csn_d      <= 1'b1;
      sck_d      <= 1'b0;
      active     <= 1'b0;
      bit_idx    <= '0;
      sh_mosi    <= '0;
      sh_miso    <= '0;
      byte_cnt   <= '0;
      hdr        <= '0;
      mosi1      <= '0;
      miso1      <= '0;
      miso2      <= '0;
      frame_done <= 1'b0;
    end else begin
      csn_d      <= csn;
      sck_d      <= sck;
      frame_done <= 1'b0;
      if (cs_fall) begin
        active   <= 1'b1;
        bit_idx  <= '0;
        byte_cnt <= '0;
      end else if (cs_rise) begin
        active     <= 1'b0;
        frame_done <= active;
      end else if (active && !csn && sck_rise) begin
        sh_mosi <= nxt_mosi;
        sh_miso <= nxt_miso;
        bit_idx <= bit_idx + 3'd1;
        if (bit_idx == 3'd7) begin
          case (byte_cnt)
            CNT_W'(0): hdr <= nxt_mosi;
            CNT_W'(1): begin
              mosi1 <= nxt_mosi;
              miso1 <= nxt_miso;
            end
            CNT_W'(2): miso2 <= nxt_miso;
            default: ;
          endcase
          if (byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + CNT_W'(1);
        end
      end
    end
  end

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    byte_cnt <= CNT_MAX);
  p_new_frame_clears_r12: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> (byte_cnt == '0) && (bit_idx == '0));
endmodule

// File: rtl/spi_mon_decode.sv
module spi_mon_decode
  import spi_mon_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_done,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic [7:0]        hdr,
  input  logic [7:0]        mosi1,
  input  logic [7:0]        miso1,
  input  logic [7:0]        miso2,
  output logic              rpt_valid,
  output logic [2:0]        rpt_op,
  output logic [4:0]        rpt_addr,
  output logic [1:0]        rpt_bank,
  output logic              rpt_bank_known,
  output logic [7:0]        rpt_data,
  output logic [LEN_W-1:0]  rpt_len,
  output logic [FLAG_W-1:0] rpt_flags
);
  logic [1:0]        bank_q, known_q, nbank, nknown;
  logic [FLAG_W-1:0] flags;
  logic [7:0]        data;
  logic [LEN_W-1:0]  len;
  logic [2:0]        op;
  logic [4:0]        addr;
  logic              bank_ok, reg_acc, n1, n2, n3, mac, rsvd;

  assign op      = hdr[7:5];
  assign addr    = hdr[4:0];
  assign bank_ok = &known_q;
  assign n1      = (byte_cnt == CNT_W'(1));
  assign n2      = (byte_cnt == CNT_W'(2));
  assign n3      = (byte_cnt == CNT_W'(3));
  assign mac     = is_mac_reg(bank_q, addr);
  assign rsvd    = is_rsvd_reg(bank_q, addr);

  always_comb begin
    flags   = '0;
    data    = '0;
    len     = '0;
    nbank   = bank_q;
    nknown  = known_q;
    reg_acc = 1'b0;
    case (op)
      OP_RD_CTL: begin
        if (!(n2 || n3)) flags[F_LEN] = 1'b1;
        else begin
          reg_acc = 1'b1;
          data    = n3 ? miso2 : miso1;
          if (bank_ok && (mac != n3)) flags[F_DUMMY] = 1'b1;
        end
      end
      OP_RD_BUF, OP_WR_BUF: begin
        if (hdr != ((op == OP_RD_BUF) ? RD_BUF_HDR : WR_BUF_HDR)) flags[F_HDR] = 1'b1;
        else len = LEN_W'(byte_cnt - CNT_W'(1));
      end
      OP_WR_CTL, OP_BIT_SET, OP_BIT_CLR: begin
        if (!n2) flags[F_LEN] = 1'b1;
        else begin
          reg_acc = 1'b1;
          data    = mosi1;
          if (addr == BANK_SEL_ADDR) begin
            if (op == OP_WR_CTL) begin
              nbank  = mosi1[1:0];
              nknown = 2'b11;
            end else begin
              for (int i = 0; i < 2; i++) begin
                if (mosi1[i]) begin
                  nbank[i]  = (op == OP_BIT_SET);
                  nknown[i] = 1'b1;
                end
              end
            end
          end
        end
      end
      OP_SYS_RST: begin
        if (!n1) flags[F_LEN] = 1'b1;
        else begin
          nbank  = 2'b00;
          nknown = 2'b11;
        end
      end
      default: flags[F_OPC] = 1'b1;
    endcase
    if (reg_acc) begin
      if (!bank_ok) flags[F_BANK] = 1'b1;
      else if (rsvd) flags[F_RSVD] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q         <= '0;
      known_q        <= '0;
      rpt_valid      <= 1'b0;
      rpt_op         <= '0;
      rpt_addr       <= '0;
      rpt_bank       <= '0;
      rpt_bank_known <= 1'b0;
      rpt_data       <= '0;
      rpt_len        <= '0;
      rpt_flags      <= '0;
    end else begin
      rpt_valid <= 1'b0;
      if (frame_done && (byte_cnt != '0)) begin
        rpt_valid      <= 1'b1;
        rpt_op         <= op;
        rpt_addr       <= addr;
        rpt_bank       <= bank_ok ? bank_q : 2'b00;
        rpt_bank_known <= bank_ok;
        rpt_data       <= data;
        rpt_len        <= len;
        rpt_flags      <= flags;
        bank_q         <= nbank;
        known_q        <= nknown;
      end
    end
  end

  p_valid_after_frame_r1: assert property (@(posedge clk) disable iff (rst)
    rpt_valid |-> $past(frame_done));
  p_valid_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    rpt_valid |=> !rpt_valid);
  p_unknown_op_alone_r2: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && rpt_op == 3'b110) |-> (rpt_flags == FLAG_W'(1)));
  p_len_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && rpt_op != 3'b001 && rpt_op != 3'b011) |-> (rpt_len == '0));
  p_src_bank_r6: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && rpt_op == 3'b111 && !rpt_flags[F_LEN]) |-> (bank_q == 2'b00 && known_q == 2'b11));
  p_bank_unknown_r7: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && rpt_flags[F_BANK]) |-> !rpt_bank_known);
  p_len_err_keeps_bank_r4: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && rpt_flags[F_LEN]) |-> ($stable(bank_q) && $stable(known_q)));
endmodule

// File: rtl/spi_cmd_monitor.sv
module spi_cmd_monitor
  import spi_mon_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_csn,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              spi_miso,
  output logic              rpt_valid,
  output logic [2:0]        rpt_op,
  output logic [4:0]        rpt_addr,
  output logic [1:0]        rpt_bank,
  output logic              rpt_bank_known,
  output logic [7:0]        rpt_data,
  output logic [LEN_W-1:0]  rpt_len,
  output logic [FLAG_W-1:0] rpt_flags
);
  localparam int CNT_W = LEN_W + 1;

  logic [3:0]       pins_s;
  logic             frame_done;
  logic [CNT_W-1:0] byte_cnt;
  logic [7:0]       hdr, mosi1, miso1, miso2;

  spi_mon_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_csn, spi_sck, spi_mosi, spi_miso}),
    .q   (pins_s)
  );

  spi_mon_deser #(.CNT_W(CNT_W)) u_deser (
    .clk        (clk),
    .rst        (rst),
    .csn        (pins_s[3]),
    .sck        (pins_s[2]),
    .mosi       (pins_s[1]),
    .miso       (pins_s[0]),
    .frame_done (frame_done),
    .byte_cnt   (byte_cnt),
    .hdr        (hdr),
    .mosi1      (mosi1),
    .miso1      (miso1),
    .miso2      (miso2)
  );

  spi_mon_decode #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_decode (
    .clk            (clk),
    .rst            (rst),
    .frame_done     (frame_done),
    .byte_cnt       (byte_cnt),
    .hdr            (hdr),
    .mosi1          (mosi1),
    .miso1          (miso1),
    .miso2          (miso2),
    .rpt_valid      (rpt_valid),
    .rpt_op         (rpt_op),
    .rpt_addr       (rpt_addr),
    .rpt_bank       (rpt_bank),
    .rpt_bank_known (rpt_bank_known),
    .rpt_data       (rpt_data),
    .rpt_len        (rpt_len),
    .rpt_flags      (rpt_flags)
  );
endmodule

// File: tb/sim_spi_cmd_monitor.sv
module sim_spi_cmd_monitor;
  localparam int LEN_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csn = 1'b1, sck = 1'b0, mosi = 1'b0, miso = 1'b0;
  logic             rpt_valid;
  logic [2:0]       rpt_op;
  logic [4:0]       rpt_addr;
  logic [1:0]       rpt_bank;
  logic             rpt_bank_known;
  logic [7:0]       rpt_data;
  logic [LEN_W-1:0] rpt_len;
  logic [5:0]       rpt_flags;

  always #5 clk = ~clk;

  spi_cmd_monitor #(.LEN_W(LEN_W)) u0 (
    .clk(clk), .rst(rst), .spi_csn(csn), .spi_sck(sck), .spi_mosi(mosi), .spi_miso(miso),
    .rpt_valid(rpt_valid), .rpt_op(rpt_op), .rpt_addr(rpt_addr), .rpt_bank(rpt_bank),
    .rpt_bank_known(rpt_bank_known), .rpt_data(rpt_data), .rpt_len(rpt_len), .rpt_flags(rpt_flags)
  );

  typedef struct packed {
    logic [2:0] op; logic [4:0] addr; logic [1:0] bank; logic bk;
    logic [7:0] data; logic [LEN_W-1:0] len; logic [5:0] flags;
  } rpt_t;

  rpt_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0, n_err = 0;
  bit    finished = 0;
  logic [7:0] tx_mo [32];
  logic [7:0] tx_mi [32];
  int m_bank [2];
  int m_known [2];

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit mac_cls(int b, int a);
    return (b == 2 && a <= 'h19) || (b == 3 && a <= 5);
  endfunction
  function automatic bit rsvd_cls(int b, int a);
    return (a == 'h1A) || (b == 3 && a >= 'h0F && a <= 'h11);
  endfunction

  // Behavioural expectation from the requirements
  function automatic rpt_t model(int n);
    rpt_t e;
    int hdr = tx_mo[0], op = hdr >> 5, a = hdr & 31;
    int known = m_known[0] && m_known[1];
    int bk = m_bank[1] * 2 + m_bank[0];
    bit racc = 0;
    e = '0;
    e.op = op[2:0]; e.addr = a[4:0]; e.bk = known[0];
    e.bank = known ? bk[1:0] : 2'b00;
    if (op == 0) begin
      if (n != 2 && n != 3) e.flags[2] = 1;
      else begin
        racc = 1;
        e.data = (n == 3) ? tx_mi[2] : tx_mi[1];
        if (known && (mac_cls(bk, a) != (n == 3))) e.flags[4] = 1;
      end
    end else if (op == 1 || op == 3) begin
      if (hdr != ((op == 1) ? 'h3A : 'h7A)) e.flags[1] = 1;
      else e.len = ((n - 1) > 15) ? 4'd15 : 4'(n - 1);
    end else if (op == 2 || op == 4 || op == 5) begin
      if (n != 2) e.flags[2] = 1;
      else begin
        racc = 1;
        e.data = tx_mo[1];
        if (a == 'h1F) begin
          for (int i = 0; i < 2; i++) begin
            if (op == 2) begin m_bank[i] = tx_mo[1][i]; m_known[i] = 1; end
            else if (tx_mo[1][i]) begin m_bank[i] = (op == 4); m_known[i] = 1; end
          end
        end
      end
    end else if (op == 7) begin
      if (n != 1) e.flags[2] = 1;
      else begin m_bank[0] = 0; m_bank[1] = 0; m_known[0] = 1; m_known[1] = 1; end
    end else e.flags[0] = 1;
    if (racc) begin
      if (!known) e.flags[3] = 1;
      else if (rsvd_cls(bk, a)) e.flags[5] = 1;
    end
    return e;
  endfunction

  task automatic wait_clk(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic send(string tag, int n, int extra_bits = 0);
    if (n > 0) begin
      exp_q.push_back(model(n));
      tag_q.push_back(tag);
    end
    csn = 1'b0;
    wait_clk(4);
    for (int b = 0; b < n * 8 + extra_bits; b++) begin
      mosi = tx_mo[b / 8][7 - (b % 8)];
      miso = tx_mi[b / 8][7 - (b % 8)];
      wait_clk(4);
      sck = 1'b1;
      wait_clk(4);
      sck = 1'b0;
    end
    wait_clk(4);
    csn = 1'b1;
    wait_clk(12);
    chk(tag, "report count", exp_q.size(), 0);
  endtask

  task automatic frm2(string tag, logic [7:0] h, logic [7:0] mo1, logic [7:0] mi1);
    tx_mo[0] = h; tx_mi[0] = 8'hEE; tx_mo[1] = mo1; tx_mi[1] = mi1;
    send(tag, 2);
  endtask

  // Per-clock comparison against the expected report queue
  always @(negedge clk) begin
    if (!rst && rpt_valid) begin
      if (exp_q.size() == 0) chk("R1", "unexpected report", 1, 0);
      else begin
        rpt_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, "op R2", rpt_op, e.op);
        chk(t, "addr R2", rpt_addr, e.addr);
        chk(t, "flags", rpt_flags, e.flags);
        chk(t, "bank R7", {rpt_bank_known, rpt_bank}, {e.bk, e.bank});
        chk(t, "data R11", rpt_data, e.data);
        chk(t, "len R3", rpt_len, e.len);
      end
    end
  end

  initial begin
    m_bank[0] = 0; m_bank[1] = 0; m_known[0] = 0; m_known[1] = 0;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    chk("R1", "valid after reset", rpt_valid, 0);
    chk("R7", "bank known after reset", rpt_bank_known, 0);
    // R1: empty frame and a frame of 5 bits produce nothing
    send("R1 empty", 0);
    tx_mo[0] = 8'h45; tx_mi[0] = 8'h00;
    send("R1 partial", 0, 5);
    // R7: read with unknown bank, R8 2-byte data
    frm2("R7 R8 unknown bank read", 8'h05, 8'h00, 8'hA5);
    // R5: bit set of bit 0 only leaves bank still unknown (R7)
    frm2("R5 R7 partial known", 8'h9F, 8'h01, 8'h00);
    frm2("R7 still unknown", 8'h05, 8'h00, 8'h3C);
    // R5: write loads bank 2
    frm2("R5 write bank", 8'h5F, 8'h02, 8'h00);
    // R9: MAC read without dummy in bank 2
    frm2("R9 mac no dummy", 8'h10, 8'h00, 8'h81);
    // R8 R9: 3-byte MAC read ok, data from byte 2 (R12 MSB first)
    tx_mo[0] = 8'h10; tx_mo[1] = 8'h00; tx_mo[2] = 8'h00;
    tx_mi[0] = 8'h00; tx_mi[1] = 8'h11; tx_mi[2] = 8'hC3;
    send("R8 R12 dummy read", 3);
    // R10: reserved address
    frm2("R10 reserved", 8'h1A, 8'h00, 8'h77);
    // R5: set bit 0 -> bank 3, clear bit 1 -> bank 1
    frm2("R5 bit set", 8'h9F, 8'h01, 8'h00);
    frm2("R10 bank3 reserved", 8'h4F, 8'h5A, 8'h00);
    frm2("R5 bit clear", 8'hBF, 8'h02, 8'h00);
    // R9: ordinary register read with dummy byte in bank 1
    tx_mo[0] = 8'h03; tx_mi[1] = 8'h22; tx_mi[2] = 8'h99;
    send("R9 ordinary with dummy", 3);
    // R5: bit set on another address leaves bank 1
    frm2("R5 other address", 8'h85, 8'h03, 8'h00);
    // R3: buffer commands
    for (int i = 0; i < 20; i++) begin tx_mo[i] = 8'(i * 7); tx_mi[i] = 8'(i); end
    tx_mo[0] = 8'h3A;
    send("R3 buffer read", 5);
    tx_mo[0] = 8'h3B;
    send("R3 bad header", 4);
    tx_mo[0] = 8'h7A;
    send("R3 saturate", 20);
    tx_mo[0] = 8'h7A;
    send("R3 header only", 1);
    // R2: unknown opcode
    frm2("R2 unknown op", 8'hC4, 8'h00, 8'h00);
    // R4: 3-byte bank write rejected, bank unchanged
    tx_mo[0] = 8'h5F; tx_mo[1] = 8'h03; tx_mo[2] = 8'h00;
    send("R4 long write", 3);
    frm2("R4 bank kept", 8'h02, 8'h00, 8'h44);
    tx_mo[0] = 8'h02;
    send("R4 short read", 1);
    // R6: reset length error, then valid reset
    frm2("R4 R6 long reset", 8'hFF, 8'h00, 8'h00);
    tx_mo[0] = 8'hFF;
    send("R6 reset", 1);
    frm2("R6 bank zero", 8'h02, 8'h00, 8'h5E);
    // R12 R1: trailing bits after two bytes are dropped
    tx_mo[0] = 8'h5F; tx_mo[1] = 8'h03; tx_mo[2] = 8'hFF;
    send("R12 trailing bits", 2, 3);
    frm2("R11 after trailing", 8'h1B, 8'h00, 8'h6D);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule